// File: doc/BRIEF.md
# Squash-Filtered Replay Queue

This block keeps memory operations that have to be retried and hands them back to the issue path on command. Each waiting operation is held as a sequence number together with the ID of the thread that owns it. A reschedule push places the operation at the back of the queue. A replay command then empties the whole queue toward the ready path, one entry per accepted handshake. Operations pushed while the queue is draining are drained in the same pass.

A squash carries a thread ID and a sequence-number boundary. It removes every stored entry of that thread that is younger than the boundary, wherever that entry sits in the queue. The surviving entries close ranks and keep their order. Sequence numbers are compared as plain unsigned values, and "younger" means strictly greater.

An empty flag tells a drain check whether anything is still waiting. An overflow flag reports a push that was dropped because the queue had no room.

Top module: `replay_queue`

## Requirements
- R1: When reset is released, `empty_o` is 1, `rdy_valid_o` is 0 and `overflow_o` is 0.
- R2: Entries are released in the order their pushes were accepted.
- R3: A push is dropped, with `overflow_o` high in that same cycle, only when the queue still holds DEPTH entries after that cycle's squash and release. Any other push is accepted.
- R4: A one-cycle `replay_i` pulse makes `rdy_valid_o` rise in the next cycle if the queue holds entries. The queue then releases one entry per cycle in which `rdy_valid_o` and `rdy_ready_i` are both high. `rdy_valid_o` falls in the cycle after the last entry leaves.
- R5: If no replay command has been given, `rdy_valid_o` stays 0 whatever `rdy_ready_i` does, and the stored entries are kept.
- R6: While `rdy_ready_i` is low and no squash is applied, `rdy_valid_o`, `rdy_seq_o` and `rdy_tid_o` hold their values.
- R7: A squash removes exactly the stored entries with tid equal to `squash_tid_i` and seq strictly greater than `squash_seq_i`. An entry whose seq equals the boundary is kept. All kept entries stay in order.
- R8: A squash in the same cycle as a release acts first. The entry shown on the ready port is the oldest one that survives the squash, so a squashed entry is never released.
- R9: An entry pushed while a drain is in progress joins the back of the queue and is released in the same drain.
- R10: `empty_o` is 1 exactly when no entry is stored at the start of the cycle.
- R11: A squash does not affect an entry pushed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Reschedule push strobe |
| push_seq_i | input | 16 | Sequence number of the pushed operation |
| push_tid_i | input | 2 | Thread ID of the pushed operation |
| replay_i | input | 1 | Replay command: start draining the whole queue |
| squash_valid_i | input | 1 | Squash strobe |
| squash_tid_i | input | 2 | Thread that is squashed |
| squash_seq_i | input | 16 | Squash boundary; younger entries of the thread are removed |
| rdy_valid_o | output | 1 | A released entry is offered |
| rdy_ready_i | input | 1 | The ready path accepts the offered entry |
| rdy_seq_o | output | 16 | Sequence number of the offered entry |
| rdy_tid_o | output | 2 | Thread ID of the offered entry |
| empty_o | output | 1 | No entry is stored |
| overflow_o | output | 1 | The push in this cycle was dropped |

## Verification
Two pairs of functions can land in the same cycle. A squash can arrive while the head entry is being handed off, and a push can arrive during a drain or alongside a squash. The bench provokes both. It drives a squash that kills the current head in a cycle where the ready path accepts, and it checks that the port already shows the next survivor and that the victim never appears later. A push issued in the last release cycle of a drain must show up as the next offered entry. A push issued together with a squash that would otherwise match it must still be found once the queue is drained.

// File: rtl/replay_queue_pkg.sv
package replay_queue_pkg;

  localparam int unsigned SEQ_W = 16;
  localparam int unsigned TID_W = 2;

  typedef struct packed {
    logic [TID_W-1:0] tid;
    logic [SEQ_W-1:0] seq;
  } rq_entry_t;

  // An entry dies when it belongs to the squashed thread and is younger
  // (strictly larger sequence number) than the squash boundary.
  function automatic logic is_victim(input rq_entry_t e,
                                     input logic [TID_W-1:0] sq_tid,
                                     input logic [SEQ_W-1:0] sq_seq);
    return (e.tid == sq_tid) && (e.seq > sq_seq);
  endfunction

  // Queue has room for one more entry when its post-removal count is short of depth.
  function automatic logic has_room(input int unsigned remaining,
                                    input int unsigned depth);
    return remaining < depth;
  endfunction

endpackage

// File: rtl/rq_squash_filter.sv
module rq_squash_filter
  import replay_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  rq_entry_t        ent_i [DEPTH],
  input  logic [DEPTH-1:0] valid_i,
  input  logic             sq_valid_i,
  input  logic [TID_W-1:0] sq_tid_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  output logic [DEPTH-1:0] keep_o,
  output logic [DEPTH-1:0] victim_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign victim_o[i] = valid_i[i] & sq_valid_i & is_victim(ent_i[i], sq_tid_i, sq_seq_i);
    assign keep_o[i]   = valid_i[i] & ~victim_o[i];
  end

endmodule

// File: rtl/rq_head_pick.sv
module rq_head_pick
  import replay_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  rq_entry_t        ent_i [DEPTH],
  input  logic [DEPTH-1:0] keep_i,
  output logic [DEPTH-1:0] head_oh_o,
  output logic             any_o,
  output rq_entry_t        head_o
);

  // Lowest surviving slot is the oldest entry.
  assign head_oh_o = keep_i & (~keep_i + DEPTH'(1));
  assign any_o     = |keep_i;

  always_comb begin
    head_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (head_oh_o[i]) head_o = ent_i[i];
    end
  end

endmodule

// File: rtl/rq_compactor.sv
module rq_compactor
  import replay_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  rq_entry_t        ent_i [DEPTH],
  input  logic [DEPTH-1:0] mask_i,
  output rq_entry_t        ent_o [DEPTH],
  output logic [CNT_W-1:0] cnt_o
);

  // Slide every surviving entry down over the holes, keeping order.
  always_comb begin
    int unsigned pos;
    pos = 0;
    for (int j = 0; j < DEPTH; j++) ent_o[j] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mask_i[i]) begin
        ent_o[pos] = ent_i[i];
        pos = pos + 1;
      end
    end
    cnt_o = CNT_W'(pos);
  end

endmodule

// File: rtl/rq_drain_ctrl.sv
module rq_drain_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic replay_i,
  input  logic next_empty_i,
  output logic draining_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) draining_o <= 1'b0;
    else         draining_o <= (draining_o | replay_i) & ~next_empty_i;
  end

endmodule

// File: rtl/replay_queue.sv
module replay_queue
  import replay_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [15:0]      push_seq_i,
  input  logic [1:0]       push_tid_i,
  input  logic             replay_i,
  input  logic             squash_valid_i,
  input  logic [1:0]       squash_tid_i,
  input  logic [15:0]      squash_seq_i,
  output logic             rdy_valid_o,
  input  logic             rdy_ready_i,
  output logic [15:0]      rdy_seq_o,
  output logic [1:0]       rdy_tid_o,
  output logic             empty_o,
  output logic             overflow_o
);

  rq_entry_t        ent_q   [DEPTH];
  rq_entry_t        ent_d   [DEPTH];
  rq_entry_t        packed_ent [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_left;
  logic [DEPTH-1:0] valid_vec;
  logic [DEPTH-1:0] keep;
  logic [DEPTH-1:0] victim;
  logic [DEPTH-1:0] head_oh;
  logic [DEPTH-1:0] survive;
  logic             head_any;
  rq_entry_t        head_ent;
  logic             draining;
  logic             rel_fire;
  logic             push_acc;
  logic             sq_hit;

  // Occupied slots are always the low cnt_q ones.
  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    assign valid_vec[i] = (CNT_W'(i) < cnt_q);
  end

  rq_squash_filter #(.DEPTH(DEPTH)) u_filter (
    .ent_i      (ent_q),
    .valid_i    (valid_vec),
    .sq_valid_i (squash_valid_i),
    .sq_tid_i   (squash_tid_i),
    .sq_seq_i   (squash_seq_i),
    .keep_o     (keep),
    .victim_o   (victim)
  );

  rq_head_pick #(.DEPTH(DEPTH)) u_head (
    .ent_i     (ent_q),
    .keep_i    (keep),
    .head_oh_o (head_oh),
    .any_o     (head_any),
    .head_o    (head_ent)
  );

  assign rdy_valid_o = draining & head_any;
  assign rdy_seq_o   = head_ent.seq;
  assign rdy_tid_o   = head_ent.tid;
  assign rel_fire    = rdy_valid_o & rdy_ready_i;
  assign sq_hit      = |victim;

  // Released head drops out together with the squash victims.
  assign survive = rel_fire ? (keep & ~head_oh) : keep;

  rq_compactor #(.DEPTH(DEPTH)) u_compact (
    .ent_i  (ent_q),
    .mask_i (survive),
    .ent_o  (packed_ent),
    .cnt_o  (cnt_left)
  );

  assign push_acc   = push_valid_i & has_room(int'(cnt_left), DEPTH);
  assign overflow_o = push_valid_i & ~push_acc;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) ent_d[j] = packed_ent[j];
    if (push_acc) begin
      ent_d[cnt_left[IDX_W-1:0]].seq = push_seq_i;
      ent_d[cnt_left[IDX_W-1:0]].tid = push_tid_i;
    end
    cnt_d = cnt_left + CNT_W'(push_acc);
  end

  rq_drain_ctrl u_drain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .replay_i     (replay_i),
    .next_empty_i (cnt_d == '0),
    .draining_o   (draining)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int j = 0; j < DEPTH; j++) ent_q[j] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int j = 0; j < DEPTH; j++) ent_q[j] <= ent_d[j];
    end
  end

  assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/replay_queue_chk.sv
module replay_queue_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_valid_i,
  input logic             overflow_o,
  input logic             rdy_valid_o,
  input logic             rdy_ready_i,
  input logic [15:0]      rdy_seq_o,
  input logic [1:0]       rdy_tid_o,
  input logic             squash_valid_i,
  input logic [1:0]       squash_tid_i,
  input logic [15:0]      squash_seq_i,
  input logic             empty_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             push_acc_i,
  input logic             rel_i
);

  p_valid_has_entry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_valid_o |-> !empty_o);

  p_hold_when_stalled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_valid_o && !rdy_ready_i && !squash_valid_i) |=>
      (rdy_valid_o && $stable(rdy_seq_o) && $stable(rdy_tid_o)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (push_valid_i && cnt_i == CNT_W'(DEPTH)));

  p_never_release_victim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_valid_o && squash_valid_i) |->
      !(rdy_tid_o == squash_tid_i && rdy_seq_o > squash_seq_i));

  p_count_tracks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !squash_valid_i |=>
      cnt_i == $past(cnt_i + CNT_W'(push_acc_i) - CNT_W'(rel_i)));

endmodule

bind replay_queue replay_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .push_valid_i   (push_valid_i),
  .overflow_o     (overflow_o),
  .rdy_valid_o    (rdy_valid_o),
  .rdy_ready_i    (rdy_ready_i),
  .rdy_seq_o      (rdy_seq_o),
  .rdy_tid_o      (rdy_tid_o),
  .squash_valid_i (squash_valid_i),
  .squash_tid_i   (squash_tid_i),
  .squash_seq_i   (squash_seq_i),
  .empty_o        (empty_o),
  .cnt_i          (cnt_q),
  .push_acc_i     (push_acc),
  .rel_i          (rel_fire)
);

// File: tb/replay_queue_tb.sv
module replay_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic [15:0] push_seq = '0;
  logic [1:0]  push_tid = '0;
  logic        replay = 1'b0;
  logic        sq_valid = 1'b0;
  logic [1:0]  sq_tid = '0;
  logic [15:0] sq_seq = '0;
  logic        rdy_ready = 1'b0;
  logic        rdy_valid;
  logic [15:0] rdy_seq;
  logic [1:0]  rdy_tid;
  logic        empty;
  logic        overflow;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  replay_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_valid), .push_seq_i(push_seq), .push_tid_i(push_tid),
    .replay_i(replay),
    .squash_valid_i(sq_valid), .squash_tid_i(sq_tid), .squash_seq_i(sq_seq),
    .rdy_valid_o(rdy_valid), .rdy_ready_i(rdy_ready),
    .rdy_seq_o(rdy_seq), .rdy_tid_o(rdy_tid),
    .empty_o(empty), .overflow_o(overflow)
  );

  // Vector: push, pseq, ptid, replay, sq, sqtid, sqseq, ready, exp_valid, exp_seq
  localparam int VW = 57;
  function automatic logic [VW-1:0] mk(input logic p, input logic [15:0] ps, input logic [1:0] pt,
                                       input logic rp, input logic s, input logic [1:0] st,
                                       input logic [15:0] ss, input logic rd, input logic ev,
                                       input logic [15:0] es);
    return {p, ps, pt, rp, s, st, ss, rd, ev, es};
  endfunction

  localparam int NV = 8;
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(1, 16'd10, 2'd0, 0, 0, 2'd0, 16'd0,  1, 0, 16'd0),   // R5: no replay yet
    mk(1, 16'd11, 2'd1, 0, 0, 2'd0, 16'd0,  1, 0, 16'd0),   // R5
    mk(1, 16'd12, 2'd0, 0, 0, 2'd0, 16'd0,  1, 0, 16'd0),   // R5
    mk(0, 16'd0,  2'd0, 1, 0, 2'd0, 16'd0,  0, 0, 16'd0),   // R4: valid waits a cycle
    mk(0, 16'd0,  2'd0, 0, 0, 2'd0, 16'd0,  1, 1, 16'd10),  // R2 R4: oldest first
    mk(0, 16'd0,  2'd0, 0, 1, 2'd0, 16'd10, 1, 1, 16'd11),  // R8: 12 killed, 11 shown
    mk(0, 16'd0,  2'd0, 0, 0, 2'd0, 16'd0,  1, 0, 16'd0),   // R8 R4: 12 never released
    mk(0, 16'd0,  2'd0, 0, 0, 2'd0, 16'd0,  1, 0, 16'd0)    // R4: drain over
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_valid = 0; replay = 0; sq_valid = 0; rdy_ready = 0;
  endtask

  // Advance to the next cycle's drive point (just after the falling edge).
  task automatic next_cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic push(input logic [15:0] s, input logic [1:0] t);
    next_cyc();
    push_valid = 1; push_seq = s; push_tid = t;
  endtask

  task automatic expect_out(input string req, input logic v, input logic [15:0] s);
    #5;
    check(rdy_valid === v, req, rdy_valid, v);
    if (v) check(rdy_seq === s, req, rdy_seq, s);
  endtask

  // Drain with ready high, expecting the given sequence, then an idle port.
  task automatic drain_expect(input string req, input logic [15:0] exp_q [$]);
    next_cyc(); replay = 1;
    foreach (exp_q[k]) begin
      next_cyc(); rdy_ready = 1;
      expect_out(req, 1'b1, exp_q[k]);
    end
    next_cyc(); rdy_ready = 1;
    expect_out(req, 1'b0, 16'd0);
    check(empty === 1'b1, req, empty, 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check(empty === 1'b1,     "R1", empty, 1);
    check(rdy_valid === 1'b0, "R1", rdy_valid, 0);
    check(overflow === 1'b0,  "R1", overflow, 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      next_cyc();
      {push_valid, push_seq, push_tid, replay, sq_valid, sq_tid, sq_seq, rdy_ready} = VEC[i][VW-1:17];
      expect_out("R2/R4/R5/R8 table", VEC[i][16], VEC[i][15:0]);
    end
    next_cyc();
    #5 check(empty === 1'b1, "R10", empty, 1);

    // R3: fill, then one push too many
    for (int k = 0; k < 8; k++) push(16'(100 + k), 2'd0);
    push(16'd999, 2'd0);
    #5 check(overflow === 1'b1, "R3", overflow, 1);
    next_cyc();
    #5 check(empty === 1'b0, "R10", empty, 0);
    check(overflow === 1'b0, "R3", overflow, 0);
    drain_expect("R2 R3 R4", '{16'd100, 16'd101, 16'd102, 16'd103, 16'd104, 16'd105, 16'd106, 16'd107});

    // R6: stall holds the offer
    push(16'd200, 2'd1);
    push(16'd201, 2'd1);
    next_cyc(); replay = 1;
    next_cyc(); expect_out("R6", 1'b1, 16'd200);
    next_cyc(); expect_out("R6", 1'b1, 16'd200);
    #0 check(rdy_tid === 2'd1, "R6", rdy_tid, 1);
    next_cyc(); rdy_ready = 1; expect_out("R6", 1'b1, 16'd200);
    next_cyc(); rdy_ready = 1; expect_out("R6", 1'b1, 16'd201);
    next_cyc(); rdy_ready = 1; expect_out("R6", 1'b0, 16'd0);

    // R9: push during the last release of a drain
    push(16'd300, 2'd2);
    next_cyc(); replay = 1;
    next_cyc(); rdy_ready = 1; push_valid = 1; push_seq = 16'd301; push_tid = 2'd2;
    expect_out("R9", 1'b1, 16'd300);
    next_cyc(); rdy_ready = 1; expect_out("R9", 1'b1, 16'd301);
    next_cyc(); rdy_ready = 1; expect_out("R9", 1'b0, 16'd0);

    // R7: squash entries in the middle, boundary value kept
    push(16'd400, 2'd0);
    push(16'd401, 2'd1);
    push(16'd402, 2'd0);
    push(16'd403, 2'd1);
    push(16'd404, 2'd2);
    next_cyc(); sq_valid = 1; sq_tid = 2'd1; sq_seq = 16'd400;
    next_cyc(); sq_valid = 1; sq_tid = 2'd0; sq_seq = 16'd402;
    drain_expect("R7", '{16'd400, 16'd402, 16'd404});

    // R11: push alongside a squash that would match it
    next_cyc();
    push_valid = 1; push_seq = 16'd500; push_tid = 2'd3;
    sq_valid = 1; sq_tid = 2'd3; sq_seq = 16'd0;
    next_cyc();
    #5 check(empty === 1'b0, "R11", empty, 0);
    drain_expect("R11", '{16'd500});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule